// File: doc/BRIEF.md
# Two-Packet Beat Splitter for a 256-bit Receive Stream

This block sits between a receive packet source that may pack the tail of one packet and the head of the next into a single 256-bit beat, and a consumer that accepts at most one packet per beat. Each input beat is seen as two 128-bit halves, low `[127:0]` and high `[255:128]`. Two-bit start and end flags mark the half in which a packet begins or finishes. The empty field counts unused quadwords. An eight-bit one-hot field names the address region that the packet hit.

Incoming beats go into a small skid store. The source works with a ready latency of two cycles, so a beat may arrive up to two cycles after `in_ready` falls. A two-state controller reads the head of the store. In state `ST_WHOLE` it forwards a beat unchanged. When the head beat ends a packet in its low half and starts another in its high half, the controller first emits the low half as an end beat and moves to `ST_UPPER` (transition WHOLE->UPPER, taken on a split head accepted by the consumer). The head beat stays in the store during this time, which holds back the source. In `ST_UPPER` the controller emits the high half as a start beat, pops the store and returns (transition UPPER->WHOLE, taken when the consumer accepts). On the way out, the empty count is converted to dwords and the one-hot region becomes a three-bit binary code. A sticky flag records any malformed region seen on a start beat.

Top module: `rx_pkt_splitter`

## Requirements
- R1: While in reset and right after it, `out_valid` is 0, `in_ready` is 1 and `region_err` is 0.
- R2: A head beat that is not a split beat is emitted once. Its data is unchanged, `out_sop` is the OR of both start bits and `out_eop` is the OR of both end bits.
- R3: A split beat has `in_eop`=2'b01 and `in_sop`=2'b10. It becomes two consecutive output beats. The first carries the low half, with the high half zeroed, `out_sop`=0 and `out_eop`=1. The second carries the high half in place, with the low half zeroed, `out_sop`=1, `out_eop`=0 and `out_empty`=0.
- R4: `out_empty` is 2*q+4 when the packet ends in the low half (`in_eop`=2'b01) and 2*q when it ends in the high half (`in_eop`=2'b10), where q is `in_empty`. When no packet ends in the beat, `out_empty` is 0. The source keeps q below 2 whenever the end is in the low half.
- R5: A region input with only bit k set, for k from 0 to 5, gives `out_region`=k. Only bit 6 set gives 3'b111.
- R6: A region input with no bits set, more than one bit set, or bit 7 set gives `out_region`=3'b110. Once such a beat is accepted at the output with `out_sop`=1, `region_err` is 1 from the next cycle until reset.
- R7: Every input beat that arrives at most two cycles after a cycle with `in_ready`=1 is kept. No beat is lost, duplicated or reordered, and the store never overflows.
- R8: While `out_valid`=1 and `out_ready`=0, every output field holds its value into the next cycle.
- R9: When the output is stalled, `in_ready` falls after at most the store depth of accepted beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present; legal only if `in_ready` was 1 two cycles earlier |
| in_ready | output | 1 | Grants one input beat two cycles later |
| in_data | input | 256 | Input beat, two 128-bit halves |
| in_sop | input | 2 | Start flags: bit 0 low half, bit 1 high half |
| in_eop | input | 2 | End flags: bit 0 low half, bit 1 high half |
| in_empty | input | 2 | Unused quadwords in the ending beat |
| in_region | input | 8 | One-hot region: bits 0-5 regions, bit 6 expansion ROM, bit 7 reserved |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_data | output | 256 | Output beat |
| out_sop | output | 1 | Packet starts in this beat |
| out_eop | output | 1 | Packet ends in this beat |
| out_empty | output | 3 | Unused dwords in the ending beat |
| out_region | output | 3 | Binary region code |
| region_err | output | 1 | Sticky flag for a malformed region on a start beat |

## Verification
The assertions take three things for granted about the source. It raises `in_valid` only when `in_ready` was high two cycles before. It never sets both start bits or both end bits in one beat. It keeps the quadword count below 2 when a packet ends in the low half. The stimulus builds legal packet framing from a small in-packet state machine and delays every send against the ready value it sampled two cycles earlier. It draws the empty count within those bounds and saves malformed regions for a final phase, so that the sticky flag can be observed both before and after it is set.

// File: rtl/rps_pkg.sv
package rps_pkg;
    localparam int DATA_W   = 256;
    localparam int HALF_W   = DATA_W / 2;
    localparam int REGION_W = 8;
    localparam int CODE_W   = 3;
    localparam int EMPTY_IW = 2;
    localparam int EMPTY_OW = 3;
    localparam int ROM_BIT  = 6;
    localparam logic [CODE_W-1:0] CODE_UNUSED = 3'b110;
    localparam logic [CODE_W-1:0] CODE_ROM    = 3'b111;

    typedef struct packed {
        logic [DATA_W-1:0]   data;
        logic [1:0]          sop;
        logic [1:0]          eop;
        logic [EMPTY_IW-1:0] empty;
        logic [REGION_W-1:0] region;
    } beat_t;

    typedef enum logic {ST_WHOLE, ST_UPPER} split_state_e;
endpackage

// File: rtl/rps_skid_fifo.sv
module rps_skid_fifo
    import rps_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  beat_t         din,
    input  logic          pop,
    output beat_t         dout,
    output logic [CW-1:0] count,
    output logic          not_empty
);
    beat_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout      = mem[rd_ptr];
    assign not_empty = (count != '0);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);
endmodule

// File: rtl/rps_credit.sv
module rps_credit #(
    parameter int DEPTH = 4,
    parameter int LAT   = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          in_valid,
    output logic          in_ready
);
    logic [LAT-1:0] grant_hist;
    int             pending;

    generate
        if (LAT > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) grant_hist <= '0;
                else        grant_hist <= {grant_hist[LAT-2:0], in_ready};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) grant_hist <= '0;
                else        grant_hist <= in_ready;
            end
        end
    endgenerate

    always_comb begin
        pending = 0;
        for (int i = 0; i < LAT; i++) pending += int'(grant_hist[i]);
        in_ready = (int'(count) + pending) < DEPTH;
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> grant_hist[LAT-1]);
endmodule

// File: rtl/rps_region_enc.sv
module rps_region_enc
    import rps_pkg::*;
(
    input  logic [REGION_W-1:0] region_oh,
    output logic [CODE_W-1:0]   code,
    output logic                bad
);
    int                ones;
    logic [CODE_W-1:0] idx;

    always_comb begin
        ones = 0;
        idx  = '0;
        for (int i = 0; i <= ROM_BIT; i++) begin
            if (region_oh[i]) begin
                ones++;
                idx = CODE_W'(i);
            end
        end
        bad = (ones != 1) || region_oh[REGION_W-1];
        if (bad)                          code = CODE_UNUSED;
        else if (idx == CODE_W'(ROM_BIT)) code = CODE_ROM;
        else                              code = idx;
    end
endmodule

// File: rtl/rx_pkt_splitter.sv
module rx_pkt_splitter
    import rps_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LAT   = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [1:0]          in_sop,
    input  logic [1:0]          in_eop,
    input  logic [EMPTY_IW-1:0] in_empty,
    input  logic [REGION_W-1:0] in_region,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_sop,
    output logic                out_eop,
    output logic [EMPTY_OW-1:0] out_empty,
    output logic [CODE_W-1:0]   out_region,
    output logic                region_err
);
    beat_t         in_beat;
    beat_t         head;
    logic [CW-1:0] count;
    logic          have_head;
    logic          pop;
    logic          split;
    logic          head_bad;
    logic [EMPTY_OW-1:0] dw_base;
    split_state_e  state, state_n;

    assign in_beat = '{data: in_data, sop: in_sop, eop: in_eop,
                       empty: in_empty, region: in_region};

    rps_skid_fifo #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(in_valid), .din(in_beat),
        .pop(pop), .dout(head), .count(count), .not_empty(have_head)
    );

    rps_credit #(.DEPTH(DEPTH), .LAT(LAT)) u_credit (
        .clk(clk), .rst_n(rst_n), .count(count),
        .in_valid(in_valid), .in_ready(in_ready)
    );

    rps_region_enc u_region (
        .region_oh(head.region), .code(out_region), .bad(head_bad)
    );

    assign split   = (head.eop == 2'b01) && head.sop[1];
    assign dw_base = EMPTY_OW'({head.empty, 1'b0});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WHOLE;
        else        state <= state_n;
    end

    // Transitions and store pop
    always_comb begin
        state_n = state;
        pop     = 1'b0;
        unique case (state)
            ST_WHOLE: begin
                if (have_head && out_ready) begin
                    if (split) state_n = ST_UPPER;
                    else       pop     = 1'b1;
                end
            end
            ST_UPPER: begin
                if (out_ready) begin
                    pop     = 1'b1;
                    state_n = ST_WHOLE;
                end
            end
        endcase
    end

    // Output beat formation
    always_comb begin
        out_valid = have_head;
        out_data  = head.data;
        out_sop   = |head.sop;
        out_eop   = |head.eop;
        out_empty = '0;
        unique case (state)
            ST_WHOLE: begin
                if (split) begin
                    out_data  = {{HALF_W{1'b0}}, head.data[HALF_W-1:0]};
                    out_sop   = 1'b0;
                    out_eop   = 1'b1;
                    out_empty = dw_base + EMPTY_OW'(4);
                end else if (head.eop == 2'b01) begin
                    out_empty = dw_base + EMPTY_OW'(4);
                end else if (head.eop == 2'b10) begin
                    out_empty = dw_base;
                end
            end
            ST_UPPER: begin
                out_data = {head.data[DATA_W-1:HALF_W], {HALF_W{1'b0}}};
                out_sop  = 1'b1;
                out_eop  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                         region_err <= 1'b0;
        else if (out_valid && out_ready && out_sop && head_bad) region_err <= 1'b1;
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
            && $stable(out_eop) && $stable(out_empty) && $stable(out_region));
    assert_upper_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPPER) |-> out_valid && out_sop && !out_eop);
    assert_low_end_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_eop == 2'b01) |-> (in_empty < 2'd2));
    assert_err_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_sop && (out_region == CODE_UNUSED) |=> region_err);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        region_err |=> region_err);
endmodule

// File: tb/rx_pkt_splitter_tb.sv
`timescale 1ns/1ps
module rx_pkt_splitter_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [255:0] in_data;
    logic [1:0]   in_sop, in_eop, in_empty;
    logic [7:0]   in_region;
    logic         out_valid, out_ready;
    logic [255:0] out_data;
    logic         out_sop, out_eop;
    logic [2:0]   out_empty, out_region;
    logic         region_err;

    always #2 clk = ~clk;

    rx_pkt_splitter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .in_region(in_region), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_empty(out_empty), .out_region(out_region), .region_err(region_err)
    );

    typedef struct {
        logic [255:0] data;
        logic         sop, eop;
        logic [2:0]   empty, code;
        bit           from_split;
    } exp_t;

    exp_t   exp_q[$];
    int     checks = 0;
    int     fails  = 0;
    bit     exp_err = 0;
    bit     in_pkt = 0;
    bit     rdy_d1 = 0, rdy_d2 = 0;
    bit     stalled = 0;
    logic [255:0] held_data;
    bit     finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [2:0] ref_code(input logic [7:0] r);
        int n = 0;
        int k = 0;
        for (int i = 0; i < 7; i++) if (r[i]) begin n++; k = i; end
        if (n != 1 || r[7]) return 3'd6;
        return (k == 6) ? 3'd7 : 3'(k);
    endfunction

    function automatic logic [7:0] pick_region(input bit bad_ok);
        if (bad_ok && ($urandom % 3 == 0)) begin
            case ($urandom % 4)
                0: return 8'h00;
                1: return 8'h80;
                2: return 8'h03;
                default: return 8'h41;
            endcase
        end
        return 8'h01 << ($urandom % 7);
    endfunction

    task automatic expand(input logic [255:0] d, input logic [1:0] s, input logic [1:0] e,
                          input logic [1:0] q, input logic [7:0] r);
        exp_t x;
        x.code = ref_code(r);
        if (e == 2'b01 && s[1]) begin
            x.data = {128'b0, d[127:0]}; x.sop = 0; x.eop = 1;
            x.empty = 3'(2 * q + 4); x.from_split = 1;
            exp_q.push_back(x);
            x.data = {d[255:128], 128'b0}; x.sop = 1; x.eop = 0;
            x.empty = 0;
            exp_q.push_back(x);
        end else begin
            x.data = d; x.sop = |s; x.eop = |e; x.from_split = 0;
            x.empty = (e == 2'b01) ? 3'(2 * q + 4) : (e == 2'b10) ? 3'(2 * q) : 3'd0;
            exp_q.push_back(x);
        end
    endtask

    task automatic cycle(input bit src_en, input int send_pct, input bit bad_ok,
                         input int ready_pct);
        bit   allowed;
        exp_t x;
        string rq;
        @(negedge clk);
        chk("R6", "region_err", 256'(region_err), 256'(exp_err));
        if (stalled) chk("R8", "held out_data", out_data, held_data);
        allowed = rdy_d2;
        rdy_d2 = rdy_d1;
        rdy_d1 = in_ready;
        in_valid = 0;
        if (allowed && src_en && ($urandom % 100 < send_pct)) begin
            logic [1:0] s, e, q;
            int c = $urandom % 4;
            if (!in_pkt) begin
                case (c)
                    0: begin s = 2'b01; e = 2'b00; in_pkt = 1; end
                    1: begin s = 2'b01; e = 2'b10; end
                    2: begin s = 2'b01; e = 2'b01; end
                    default: begin s = 2'b10; e = 2'b00; in_pkt = 1; end
                endcase
            end else begin
                case (c)
                    0: begin s = 2'b00; e = 2'b00; end
                    1: begin s = 2'b00; e = 2'b01; in_pkt = 0; end
                    2: begin s = 2'b10; e = 2'b01; end
                    default: begin s = 2'b00; e = 2'b10; in_pkt = 0; end
                endcase
            end
            q = (e == 2'b01) ? 2'($urandom % 2) : 2'($urandom % 4);
            in_valid  = 1;
            in_data   = {$urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom, $urandom, $urandom};
            in_sop    = s;
            in_eop    = e;
            in_empty  = q;
            in_region = pick_region(bad_ok);
            expand(in_data, s, e, q, in_region);
        end
        out_ready = ($urandom % 100) < ready_pct;
        #1;
        stalled   = out_valid && !out_ready;
        held_data = out_data;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk("R7", "unexpected output beat", 256'(1), 256'(0));
            end else begin
                x  = exp_q.pop_front();
                rq = x.from_split ? "R3" : "R2";
                chk(rq, "data", out_data, x.data);
                chk(rq, "sop", 256'(out_sop), 256'(x.sop));
                chk(rq, "eop", 256'(out_eop), 256'(x.eop));
                chk("R4", "empty", 256'(out_empty), 256'(x.empty));
                chk((x.code == 3'd6) ? "R6" : "R5", "region", 256'(out_region), 256'(x.code));
                if (x.sop && x.code == 3'd6) exp_err = 1;
            end
        end
    endtask

    initial begin
        rst_n = 0; in_valid = 0; out_ready = 0;
        in_data = '0; in_sop = 0; in_eop = 0; in_empty = 0; in_region = 8'h01;
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", 256'(out_valid), 256'(0));
        chk("R1", "region_err in reset", 256'(region_err), 256'(0));
        rst_n = 1;
        @(negedge clk);
        chk("R1", "in_ready after reset", 256'(in_ready), 256'(1));
        chk("R1", "out_valid after reset", 256'(out_valid), 256'(0));

        repeat (3000) cycle(1, 75, 0, 70);
        repeat (40)   cycle(0, 0, 0, 100);
        // R9: stalled output with an eager source
        repeat (14)   cycle(1, 100, 0, 0);
        chk("R9", "in_ready while stalled", 256'(in_ready), 256'(0));
        chk("R9", "beats held while stalled", 256'(exp_q.size() <= 8), 256'(1));
        repeat (3000) cycle(1, 90, 0, 50);
        chk("R6", "no error with clean regions", 256'(exp_err), 256'(0));
        repeat (2000) cycle(1, 75, 1, 80);
        repeat (40)   cycle(0, 0, 0, 100);
        chk("R6", "error seen after bad regions", 256'(region_err), 256'(1));
        chk("R7", "all beats delivered", 256'(exp_q.size()), 256'(0));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule